// File: doc/BRIEF.md
# Six-Step Commutation Sequencer

This block drives the three channels of a three-phase bridge through a fixed rotation of six commutation steps. Each channel is placed in one of three states: switched off (both line enables low), driven high (reference active, both line enables high) or driven low (reference inactive, both line enables high). The per-channel reference and line enables feed three complementary output stages downstream.

Every channel setting is double-buffered. A shadow pattern holds the next step's configuration, and one accepted commutation strobe copies the whole shadow into the live registers on a single clock edge. No channel can therefore change ahead of another. After each copy the block pulses a preload request for one cycle. During that cycle it refills the shadow with the pattern of the step that follows, so the live pattern never lags the step index by one.

Step patterns: step 1 = ch2 high, ch1 low, ch0 off; step 2 = ch0 high, ch1 low, ch2 off; step 3 = ch0 high, ch2 low, ch1 off; step 4 = ch1 high, ch2 low, ch0 off; step 5 = ch1 high, ch0 low, ch2 off; step 6 = ch2 high, ch0 low, ch1 off.

Top module: `six_step_seq`

## Requirements
- R1: While rst_ni is low, and after its release until the first accepted strobe, step_o is 0 and preload_req_o, ref_o, en_hi_o and en_lo_o are all 0.
- R2: ref_o, en_hi_o, en_lo_o and step_o change only on the clock edge that accepts a strobe, and all channels take their new values on that same edge.
- R3: An accepted strobe advances step_o by one, starting from 1 after reset.
- R4: An accepted strobe at step 6 sets step_o back to 1.
- R5: preload_req_o is high for exactly the one cycle that follows each accepted strobe.
- R6: A com_i strobe sampled while preload_req_o is high is ignored: the step and the outputs are unchanged, and the next accepted strobe applies the correct following step.
- R7: After the edge that accepts a strobe, the outputs show the pattern of the new step_o given in the step table above. In this pattern bit i of ref_o, en_hi_o and en_lo_o belongs to channel i.
- R8: In steps 1 to 6 exactly one channel is driven high, one is driven low and one is off, and the off channel rotates 0, 2, 1, 0, 2, 1.
- R9: A channel that is off has ref low and both enables low. A channel that is on has both enables high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| com_i | input | 1 | Commutation strobe, sampled each clock edge |
| step_o | output | 3 | Current step, 0 = idle, 1..6 |
| preload_req_o | output | 1 | One-cycle pulse after each transfer; the shadow refill happens in this cycle |
| ref_o | output | 3 | Per-channel reference level, 1 = driven high |
| en_hi_o | output | 3 | Per-channel high-side line enable |
| en_lo_o | output | 3 | Per-channel low-side line enable |

## Verification
The assertions treat com_i as a synchronous level that is sampled on every edge. They use no strobe spacing: a strobe during the preload cycle must be dropped, and the hold property covers that case. The stimulus changes com_i only on falling edges. It includes back-to-back strobes so the drop path is exercised, and it applies a reset in mid-run to reach the idle state again.

// File: rtl/six_step_pkg.sv
`timescale 1ns/1ps
package six_step_pkg;
  localparam int NUM_CH    = 3;
  localparam int NUM_STEPS = 6;
  localparam int STEP_W    = $clog2(NUM_STEPS + 1);

  typedef enum logic [1:0] {
    CH_OFF  = 2'b00,
    CH_LOW  = 2'b01,
    CH_HIGH = 2'b11
  } ch_state_e;

  typedef logic [NUM_CH-1:0][1:0] pattern_t;

  // step index following s; idle (0) and last step both lead to step 1
  function automatic logic [STEP_W-1:0] step_after(input logic [STEP_W-1:0] s);
    if (s == '0 || int'(s) >= NUM_STEPS) return STEP_W'(1);
    return s + STEP_W'(1);
  endfunction

  // channel pattern for step s; anything outside 1..NUM_STEPS is all off
  function automatic pattern_t step_pattern(input logic [STEP_W-1:0] s);
    pattern_t p;
    int k, hi, off;
    p = '0;
    if (s != '0 && int'(s) <= NUM_STEPS) begin
      k   = int'(s) - 1;
      hi  = ((k + 5) / 2) % NUM_CH;
      off = (NUM_CH - (k % NUM_CH)) % NUM_CH;
      for (int c = 0; c < NUM_CH; c++) begin
        if (c == hi)       p[c] = CH_HIGH;
        else if (c == off) p[c] = CH_OFF;
        else               p[c] = CH_LOW;
      end
    end
    return p;
  endfunction
endpackage

// File: rtl/six_step_index.sv
`timescale 1ns/1ps
module six_step_index
  import six_step_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              com_i,
  output logic              accept_o,
  output logic              req_o,
  output logic [STEP_W-1:0] step_o,
  output logic [STEP_W-1:0] next_step_o
);
  logic [STEP_W-1:0] step_q;
  logic              req_q;

  // strobe during refill cycle is dropped
  assign accept_o = com_i & ~req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      req_q  <= 1'b0;
    end else begin
      req_q <= accept_o;
      if (accept_o) step_q <= step_after(step_q);
    end
  end

  assign req_o       = req_q;
  assign step_o      = step_q;
  assign next_step_o = step_after(step_q);
endmodule

// File: rtl/six_step_shadow.sv
`timescale 1ns/1ps
module six_step_shadow
  import six_step_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [STEP_W-1:0] next_step_i,
  output pattern_t          shadow_o
);
  pattern_t shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     shadow_q <= step_pattern(STEP_W'(1));
    else if (load_i) shadow_q <= step_pattern(next_step_i);
  end

  assign shadow_o = shadow_q;
endmodule

// File: rtl/six_step_active.sv
`timescale 1ns/1ps
module six_step_active
  import six_step_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xfer_i,
  input  pattern_t          shadow_i,
  output logic [NUM_CH-1:0] ref_o,
  output logic [NUM_CH-1:0] en_hi_o,
  output logic [NUM_CH-1:0] en_lo_o
);
  pattern_t act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     act_q <= '0;
    else if (xfer_i) act_q <= shadow_i;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ref_o[c]   = (act_q[c] == CH_HIGH);
    assign en_hi_o[c] = (act_q[c] != CH_OFF);
    assign en_lo_o[c] = (act_q[c] != CH_OFF);
  end
endmodule

// File: rtl/six_step_seq.sv
`timescale 1ns/1ps
module six_step_seq
  import six_step_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              com_i,
  output logic [STEP_W-1:0] step_o,
  output logic              preload_req_o,
  output logic [NUM_CH-1:0] ref_o,
  output logic [NUM_CH-1:0] en_hi_o,
  output logic [NUM_CH-1:0] en_lo_o
);
  logic              accept;
  logic [STEP_W-1:0] next_step;
  pattern_t          shadow;

  six_step_index i_index (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .com_i       (com_i),
    .accept_o    (accept),
    .req_o       (preload_req_o),
    .step_o      (step_o),
    .next_step_o (next_step)
  );

  six_step_shadow i_shadow (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (preload_req_o),
    .next_step_i (next_step),
    .shadow_o    (shadow)
  );

  six_step_active i_active (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .xfer_i   (accept),
    .shadow_i (shadow),
    .ref_o    (ref_o),
    .en_hi_o  (en_hi_o),
    .en_lo_o  (en_lo_o)
  );
endmodule

// File: rtl/six_step_seq_chk.sv
`timescale 1ns/1ps
module six_step_seq_chk
  import six_step_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              com_i,
  input logic [STEP_W-1:0] step_o,
  input logic              preload_req_o,
  input logic [NUM_CH-1:0] ref_o,
  input logic [NUM_CH-1:0] en_hi_o,
  input logic [NUM_CH-1:0] en_lo_o
);
  AST_IDLE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o == '0 |-> (ref_o == '0 && en_hi_o == '0 && en_lo_o == '0)); // R1

  AST_HOLD_NO_COM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(com_i && !preload_req_o) |=> ($stable(step_o) && $stable(ref_o) &&
                                     $stable(en_hi_o) && $stable(en_lo_o))); // R2

  AST_STEP_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (com_i && !preload_req_o && int'(step_o) < NUM_STEPS)
      |=> step_o == $past(step_o) + STEP_W'(1)); // R3

  AST_STEP_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (com_i && !preload_req_o && int'(step_o) == NUM_STEPS) |=> step_o == STEP_W'(1)); // R4

  AST_REQ_AFTER_COM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (com_i && !preload_req_o) |=> preload_req_o); // R5

  AST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preload_req_o |=> !preload_req_o); // R5

  AST_DROP_IN_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (com_i && preload_req_o) |=> $stable(step_o)); // R6

  AST_ONE_EACH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o != '0 |-> ($countones(ref_o) == 1 &&
                      $countones(en_hi_o) == NUM_CH - 1)); // R8

  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_hi_o == en_lo_o) && ((ref_o & ~en_hi_o) == '0)); // R9
endmodule

bind six_step_seq six_step_seq_chk i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .com_i         (com_i),
  .step_o        (step_o),
  .preload_req_o (preload_req_o),
  .ref_o         (ref_o),
  .en_hi_o       (en_hi_o),
  .en_lo_o       (en_lo_o)
);

// File: tb/test_six_step_seq.sv
`timescale 1ns/1ps
module test_six_step_seq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       com_i = 1'b0;
  logic [2:0] step_o;
  logic       preload_req_o;
  logic [2:0] ref_o, en_hi_o, en_lo_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #4 clk_i = ~clk_i;

  six_step_seq i_six_step_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .com_i         (com_i),
    .step_o        (step_o),
    .preload_req_o (preload_req_o),
    .ref_o         (ref_o),
    .en_hi_o       (en_hi_o),
    .en_lo_o       (en_lo_o)
  );

  // {step, ref, enables}; walk 1..6 then wrap to 1
  localparam logic [8:0] VEC [7] = '{
    9'b001_100_110, 9'b010_001_011, 9'b011_001_101, 9'b100_010_110,
    9'b101_010_011, 9'b110_100_101, 9'b001_100_110
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_out(input string req, input logic [8:0] v);
    check({req, " step"}, 16'(step_o), 16'(v[8:6]));
    check({req, " ref"},  16'(ref_o),  16'(v[5:3]));
    check({req, " en_hi"}, 16'(en_hi_o), 16'(v[2:0]));
    check({req, " en_lo"}, 16'(en_lo_o), 16'(v[2:0]));
  endtask

  task automatic pulse_com();
    com_i = 1'b1;
    @(negedge clk_i);
    com_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check_out("R1 in reset", 9'b0);
    check("R1 req in reset", 16'(preload_req_o), 16'd0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check_out("R1 idle after release", 9'b0);
    check("R1 req idle", 16'(preload_req_o), 16'd0);

    for (int i = 0; i < 7; i++) begin
      pulse_com();
      check_out(i == 6 ? "R4 wrap" : "R3 R7 R8 step", VEC[i]);
      check("R5 req high", 16'(preload_req_o), 16'd1);
      @(negedge clk_i);
      check("R5 req low", 16'(preload_req_o), 16'd0);
      check_out("R2 hold after req", VEC[i]);
      @(negedge clk_i);
    end

    repeat (5) @(negedge clk_i);
    check_out("R2 hold without strobe", VEC[0]);

    // strobe held two cycles: second sample falls in the request cycle
    com_i = 1'b1;
    @(negedge clk_i);
    check_out("R7 step 2", VEC[1]);
    @(negedge clk_i);
    com_i = 1'b0;
    check_out("R6 drop during req", VEC[1]);
    @(negedge clk_i);
    pulse_com();
    check_out("R6 following step", VEC[2]);
    @(negedge clk_i);

    rst_ni = 1'b0;
    #1;
    check_out("R1 mid-run reset", 9'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_out("R1 idle after mid reset", 9'b0);
    pulse_com();
    check_out("R3 restart at step 1", VEC[0]);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule